// File: doc/BRIEF.md
# Two-Way Registered Bus Transceiver

This block moves a parallel word between two ports, A and B, in both directions at once. Each direction has its own output enable, latch enable, data clock and data-clock enable. With these controls a direction either passes its input straight through, keeps a stored word, or captures the input on a rising edge of its data clock. For synthesis, each port is split into an input vector, an output vector and an active-high drive-enable vector, so no tristate pins are needed.

All controls are sampled by one free-running system clock `clk`. A data-clock rising edge is found by comparing the current sample of the data clock with a registered copy of the previous sample. Each direction keeps one storage register. That register is loaded every cycle while the latch is open, and it is loaded on a qualified data-clock edge while the latch is closed.

Top module: `xcvr_bus_pair`

## Requirements
- R1: Each port's drive-enable vector has every bit equal to the inverse of the active-low output enable of the direction that drives that port. The A-to-B controls drive port B, and the B-to-A controls drive port A.
- R2: While a direction's output enable is 1, the port it drives has its drive enable at all zeros and its data output at all zeros, whatever the other controls of that direction are doing.
- R3: While the output enable is 0 and the latch enable is 1, the output equals the input in the same cycle, without a register, whatever the data clock and its enable are doing.
- R4: Each system-clock edge with latch enable at 1 loads the input into storage. After the latch enable falls, the output holds the input that was sampled at the last such edge, and a data clock that stays high adds no further load.
- R5: A data-clock rising edge is a sample of 1 when the previous sample was 0. When that edge comes with latch enable 0 and clock enable 0, storage takes the input, and the new value appears on the output from the following cycle.
- R6: While latch enable is 0 and clock enable is 1, data-clock edges are ignored and the stored value does not change.
- R7: While latch enable is 0 and the data clock is held at a steady 0 or 1, the stored value does not change.
- R8: A synchronous active-low reset clears both storage registers to zero. It also sets the previous data-clock sample to 1, so a data clock that is high when reset is released is not treated as an edge. Drive enables follow the output enables during reset.
- R9: The two directions are independent: the controls of one direction never change the output of the other direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all controls |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | WIDTH | Data arriving at port A |
| a_out | output | WIDTH | Data driven onto port A (B-to-A path) |
| a_drv | output | WIDTH | Active-high drive enable for port A |
| b_in | input | WIDTH | Data arriving at port B |
| b_out | output | WIDTH | Data driven onto port B (A-to-B path) |
| b_drv | output | WIDTH | Active-high drive enable for port B |
| a2b_out_en_n | input | 1 | Active-low output enable, A-to-B |
| a2b_latch_en | input | 1 | Latch enable (1 = transparent), A-to-B |
| a2b_dclk | input | 1 | Data clock, A-to-B |
| a2b_dclk_en_n | input | 1 | Active-low data-clock enable, A-to-B |
| b2a_out_en_n | input | 1 | Active-low output enable, B-to-A |
| b2a_latch_en | input | 1 | Latch enable (1 = transparent), B-to-A |
| b2a_dclk | input | 1 | Data clock, B-to-A |
| b2a_dclk_en_n | input | 1 | Active-low data-clock enable, B-to-A |

## Verification
The hardest case to reach is the latch enable falling while the data clock is already high and then staying high. If the design gets the edge wrong, it takes a second, unwanted load here. Random toggling rarely holds all three conditions together, so a directed step opens the latch with the data clock high, closes it, and keeps the clock high with new input data on the port. Another directed step releases reset with the data clock high. Random cycles, with the data clock toggling about half the time, then mix edges, inhibit and isolation in both directions at once.

// File: rtl/xcvr_pkg.sv
// Shared types for the two-way transceiver.
// Assumes: one control bundle per direction, all sampled by the system clock.
package xcvr_pkg;

    // Control bundle for one direction of data flow
    typedef struct packed {
        logic out_en_n;   // 1 = isolated (no drive)
        logic latch_en;   // 1 = transparent
        logic dclk;       // data clock, sampled
        logic dclk_en_n;  // 1 = data-clock edges inhibited
    } xcvr_ctrl_t;

    localparam int unsigned NUM_DIRS = 2;

endpackage

// File: rtl/xcvr_edge_sense.sv
// Finds rising edges of a data clock by comparing the current sample with a
// registered previous sample. Assumes dclk_i is already synchronous to clk.
// After reset the previous sample reads 1, so a high clock is not an edge.
module xcvr_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk_i,
    output logic rise_o
);

    logic prev_q;

    // Keep the previous sample of the data clock
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= dclk_i;
    end

    // An edge is a 1 now after a 0 in the previous cycle
    always_comb rise_o = dclk_i & ~prev_q;

    AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> !$past(dclk_i)); // R5

endmodule

// File: rtl/xcvr_hold_cell.sv
// Storage for one direction. It joins a transparent latch with an
// edge-triggered register: while the latch is open, storage follows the input
// every cycle and the output bypasses storage; while it is closed, a
// qualified edge loads storage. Assumes rise_i comes from xcvr_edge_sense.
module xcvr_hold_cell #(
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_en_i,
    input  logic             dclk_en_n_i,
    input  logic             rise_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);

    logic [WIDTH-1:0] stored_q;
    logic             edge_load;
    logic             load;

    // Qualify the data-clock edge with a closed latch and an enabled clock
    always_comb edge_load = rise_i & ~latch_en_i & ~dclk_en_n_i;
    // Storage loads when the latch is open or on a qualified edge
    always_comb load = latch_en_i | edge_load;

    // Storage register
    always_ff @(posedge clk) begin
        if (!rst_n)    stored_q <= '0;
        else if (load) stored_q <= din_i;
    end

    // The output bypasses storage while the latch is open
    always_comb dout_o = latch_en_i ? din_i : stored_q;

    AST_OPEN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en_i |=> (stored_q == $past(din_i))); // R4
    AST_EDGE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_en_i && !dclk_en_n_i && rise_i) |=> (stored_q == $past(din_i))); // R5
    AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_en_i && dclk_en_n_i) |=> $stable(stored_q)); // R6
    AST_NO_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_en_i && !rise_i) |=> $stable(stored_q)); // R7

endmodule

// File: rtl/xcvr_lane.sv
// One direction of flow: edge detection, storage and the output enable.
// Assumes the output enable is active low. The drive-enable vector replicates
// its inverse, and the data output is forced to zero while isolated.
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xcvr_ctrl_t       ctrl_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o,
    output logic [WIDTH-1:0] drv_o
);

    logic             rise;
    logic [WIDTH-1:0] cell_out;

    xcvr_edge_sense u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .dclk_i (ctrl_i.dclk),
        .rise_o (rise)
    );

    xcvr_hold_cell #(.WIDTH(WIDTH)) u_cell (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch_en_i  (ctrl_i.latch_en),
        .dclk_en_n_i (ctrl_i.dclk_en_n),
        .rise_i      (rise),
        .din_i       (din_i),
        .dout_o      (cell_out)
    );

    // Drive enable and gated data for the receiving port
    always_comb begin
        drv_o  = {WIDTH{~ctrl_i.out_en_n}};
        dout_o = ctrl_i.out_en_n ? '0 : cell_out;
    end

endmodule

// File: rtl/xcvr_bus_pair.sv
// Top level of the two-way transceiver. Lane 0 carries A to B and lane 1
// carries B to A. Assumes the ports are split into in/out/drive vectors and
// that the surrounding logic resolves any bus contention.
module xcvr_bus_pair
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_drv,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_drv,
    input  logic             a2b_out_en_n,
    input  logic             a2b_latch_en,
    input  logic             a2b_dclk,
    input  logic             a2b_dclk_en_n,
    input  logic             b2a_out_en_n,
    input  logic             b2a_latch_en,
    input  logic             b2a_dclk,
    input  logic             b2a_dclk_en_n
);

    xcvr_ctrl_t       ctrl [NUM_DIRS];
    logic [WIDTH-1:0] lane_in  [NUM_DIRS];
    logic [WIDTH-1:0] lane_out [NUM_DIRS];
    logic [WIDTH-1:0] lane_drv [NUM_DIRS];

    // Gather each direction's controls and source data
    always_comb begin
        ctrl[0]    = '{out_en_n: a2b_out_en_n, latch_en: a2b_latch_en,
                       dclk: a2b_dclk, dclk_en_n: a2b_dclk_en_n};
        ctrl[1]    = '{out_en_n: b2a_out_en_n, latch_en: b2a_latch_en,
                       dclk: b2a_dclk, dclk_en_n: b2a_dclk_en_n};
        lane_in[0] = a_in;
        lane_in[1] = b_in;
    end

    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_lane
        xcvr_lane #(.WIDTH(WIDTH)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .ctrl_i (ctrl[d]),
            .din_i  (lane_in[d]),
            .dout_o (lane_out[d]),
            .drv_o  (lane_drv[d])
        );
    end

    // Route each lane to the port it drives
    always_comb begin
        b_out = lane_out[0];
        b_drv = lane_drv[0];
        a_out = lane_out[1];
        a_drv = lane_drv[1];
    end

    AST_B_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        a2b_out_en_n |-> (b_out == '0 && b_drv == '0)); // R2
    AST_A_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        b2a_out_en_n |-> (a_out == '0 && a_drv == '0)); // R2

endmodule

// File: tb/xcvr_bus_pair_bench.sv
module xcvr_bus_pair_bench;

    localparam int unsigned W = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic         oe_n [2];
    logic         le   [2];
    logic         dk   [2];
    logic         cn   [2];
    logic [W-1:0] din  [2];
    logic [W-1:0] a_out, a_drv, b_out, b_drv;

    xcvr_bus_pair #(.WIDTH(W)) u_xcvr_bus_pair (
        .clk(clk), .rst_n(rst_n),
        .a_in(din[0]), .a_out(a_out), .a_drv(a_drv),
        .b_in(din[1]), .b_out(b_out), .b_drv(b_drv),
        .a2b_out_en_n(oe_n[0]), .a2b_latch_en(le[0]),
        .a2b_dclk(dk[0]), .a2b_dclk_en_n(cn[0]),
        .b2a_out_en_n(oe_n[1]), .b2a_latch_en(le[1]),
        .b2a_dclk(dk[1]), .b2a_dclk_en_n(cn[1])
    );

    // Reference model state
    logic [W-1:0] m_st   [2];
    logic         m_pv   [2];
    int           m_kind [2];   // 0 none, 1 open-latch load, 2 edge load
    int tests = 0;
    int fails = 0;
    bit done  = 0;
    string tag_ovr = "";

    function automatic logic [W-1:0] exp_out(int d);
        if (oe_n[d]) return '0;
        return le[d] ? din[d] : m_st[d];
    endfunction

    function automatic string out_tag(int d);
        if (tag_ovr != "" && d == 1) return tag_ovr;
        if (!rst_n || m_kind[d] < 0) return "R8";
        if (oe_n[d]) return "R2";
        if (le[d]) return "R3";
        if (m_kind[d] == 2) return "R5";
        if (m_kind[d] == 1) return "R4";
        if (cn[d]) return "R6";
        return "R7";
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, check mid-phase, update the model at the rising edge
    task automatic cycle(input logic o0, l0, k0, c0, input logic [W-1:0] d0,
                         input logic o1, l1, k1, c1, input logic [W-1:0] d1);
        @(negedge clk);
        oe_n[0] = o0; le[0] = l0; dk[0] = k0; cn[0] = c0; din[0] = d0;
        oe_n[1] = o1; le[1] = l1; dk[1] = k1; cn[1] = c1; din[1] = d1;
        #5;
        chk(out_tag(0), b_out, exp_out(0));
        chk(out_tag(1), a_out, exp_out(1));
        chk("R1", b_drv, {W{~oe_n[0]}});
        chk("R1", a_drv, {W{~oe_n[1]}});
        @(posedge clk);
        for (int d = 0; d < 2; d++) begin
            if (!rst_n) begin
                m_st[d] = '0; m_pv[d] = 1'b1; m_kind[d] = -1;
            end else begin
                if (le[d]) begin
                    m_st[d] = din[d]; m_kind[d] = 1;
                end else if (!cn[d] && dk[d] && !m_pv[d]) begin
                    m_st[d] = din[d]; m_kind[d] = 2;
                end else if (m_kind[d] != -1 || le[d]) begin
                    m_kind[d] = (m_kind[d] == 1 && dk[d] && m_pv[d]) ? 1 : 0;
                end
                m_pv[d] = dk[d];
            end
        end
    endtask

    function automatic logic [W-1:0] rnd();
        return W'($urandom);
    endfunction

    initial begin : main
        void'($urandom(32'd2024));
        for (int d = 0; d < 2; d++) begin
            oe_n[d] = 1'b0; le[d] = 1'b0; dk[d] = 1'b1; cn[d] = 1'b0;
            din[d] = '0; m_st[d] = '0; m_pv[d] = 1'b1; m_kind[d] = -1;
        end
        // R8: reset with outputs enabled, data clock high
        rst_n = 1'b0;
        repeat (3) cycle(0,0,1,0,rnd(), 0,0,1,0,rnd());
        rst_n = 1'b1;
        // R8: clock still high after release is not an edge
        repeat (2) cycle(0,0,1,0,rnd(), 0,0,1,0,rnd());
        // R3: transparent with clock inhibited and toggling
        cycle(0,1,0,1,18'h2AAAA, 0,1,1,1,18'h15555);
        cycle(0,1,1,1,18'h3FFFF, 0,1,0,0,18'h00001);
        // R4: close latch while data clock high, keep it high
        cycle(0,1,1,0,18'h12345, 0,1,1,0,18'h0ABCD);
        cycle(0,0,1,0,18'h3C3C3, 0,0,1,0,18'h11111);
        cycle(0,0,1,0,18'h00F0F, 0,0,1,0,18'h22222);
        // R6: inhibited edges
        cycle(0,0,0,1,rnd(), 0,0,0,1,rnd());
        cycle(0,0,1,1,rnd(), 0,0,1,1,rnd());
        cycle(0,0,1,1,rnd(), 0,0,1,1,rnd());
        // R5: qualified edge
        cycle(0,0,0,0,rnd(), 0,0,0,0,rnd());
        cycle(0,0,1,0,18'h2D2D2, 0,0,1,0,18'h1E1E1);
        cycle(0,0,1,0,rnd(), 0,0,1,0,rnd());
        // R7: steady low
        cycle(0,0,0,0,rnd(), 0,0,0,0,rnd());
        cycle(0,0,0,0,rnd(), 0,0,0,0,rnd());
        // R2: isolation with latch open
        cycle(1,1,1,0,rnd(), 1,0,0,0,rnd());
        // R9: one direction transparent while the other loads on an edge
        tag_ovr = "R9";
        cycle(0,1,0,0,rnd(), 0,0,0,0,rnd());
        cycle(0,1,1,0,rnd(), 0,0,1,0,18'h30303);
        cycle(0,1,0,1,rnd(), 0,0,0,0,rnd());
        cycle(1,0,1,0,rnd(), 0,0,0,1,rnd());
        tag_ovr = "";
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] o, l, c, k;
            for (int d = 0; d < 2; d++) begin
                o[d] = ($urandom_range(9) < 2);
                l[d] = ($urandom_range(3) == 0);
                c[d] = ($urandom_range(9) < 3);
                k[d] = ($urandom_range(1) == 1) ? ~dk[d] : dk[d];
            end
            cycle(o[0],l[0],k[0],c[0],rnd(), o[1],l[1],k[1],c[1],rnd());
        end
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule